// File: doc/BRIEF.md
# Flash Command Reset Sequencer

This block is the command front end of an embedded flash controller that deals with getting the array back into normal read mode. It watches the microcontroller's write cycles (address, data, write strobe) and recognises a reset command. The command is either a lone write of F0h or the same write after a two-write unlock prefix. It also tracks which operation the array is in and what the external reset pin is doing. From these it decides whether the reset is ignored, takes effect at once, or aborts the running operation and starts a timed recovery.

The array algorithms are outside the block. An operation is launched by a one-cycle start strobe with an operation kind, and the array model reports progress through a busy and a fail input. The block drives one-cycle abort strobes back to that model. It exposes its current mode, a ready flag, a flag telling whether reads return status instead of array data, and a status byte that carries the error flag on data bit 5. The recovery length is `CLK_MHZ * RECOV_US` clock cycles.

Top module: `flash_rst_seq`

## Requirements
- R1: After a synchronous reset, mode is READ (0), ready is 1, read_status is 0, status is 80h and both abort strobes are 0.
- R2: A write of F0h at any address, with no unlock step pending, is a reset command. It moves mode QUERY (1) to READ in the next cycle. In READ it changes nothing and fires no strobe.
- R3: The writes AAh at 555h, then 55h at AAAh, then F0h at any address form a prefixed reset command with the same effect as R2.
- R4: A prefix write with the wrong address or data abandons the prefix. AAh at 555h in any prefix position restarts it at step one. F0h written as the second prefix step is not a command. A non-F0h value written after a complete prefix is not a command and clears the prefix.
- R5: With op_start high in READ, mode becomes QUERY, PROG (2), BULK (3) or SECT (4) for op_kind 0, 1, 2 or 3. op_start has no effect in any other mode. ready is 0 in PROG, BULK, SECT and RECOV (6).
- R6: In PROG, BULK or SECT, a cycle with arr_busy low ends the operation. With arr_fail low the mode becomes READ. With arr_fail high it becomes ERR (5) and status bit 5 becomes 1.
- R7: A reset command in PROG or BULK is ignored, and the mode holds until the operation ends.
- R8: A reset command in SECT raises abort_erase for exactly one cycle and enters RECOV. ready then stays 0 for exactly CLK_MHZ*RECOV_US cycles counted from the command's clock edge, and the mode then becomes READ.
- R9: A reset command in ERR enters RECOV for the same length as in R8. Status bit 5 stays 1 until mode READ is reached and is 0 in READ.
- R10: pin_rst high in PROG, BULK or SECT raises abort_all for one cycle and enters RECOV. The recovery restarts on every cycle pin_rst is high and runs its full length after the last of them. In QUERY or ERR, pin_rst gives READ next cycle with no strobe and clears the error flag. It also discards any partial unlock prefix.
- R11: read_status is 1 in every mode except READ. status holds ready on bit 7, the error flag on bit 5, and 0 on all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_rst | input | 1 | External reset pin, active high |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 12 | Bus write address |
| wr_data | input | 8 | Bus write data |
| op_start | input | 1 | One-cycle launch of an operation |
| op_kind | input | 2 | 0 query, 1 program, 2 bulk erase, 3 sector erase |
| arr_busy | input | 1 | Array model still working |
| arr_fail | input | 1 | Array model reports failure when the operation ends |
| mode | output | 3 | Current mode code |
| ready | output | 1 | Low while an operation or recovery runs |
| read_status | output | 1 | Reads return status instead of array data |
| status | output | 8 | Status byte, bit 5 error, bit 7 ready |
| abort_erase | output | 1 | One-cycle strobe aborting a sector erase |
| abort_all | output | 1 | One-cycle strobe aborting any array operation |

## Verification
The reset command, in its single-write and its prefixed form, is applied in each of the modes query, program, bulk erase, sector erase and error. This separates the modes that ignore it, the ones that obey it at once and the ones that take the timed path, and the recovery length is counted in cycles. Prefix sequences that are broken at each step, restarted mid-way or followed by a non-reset value show whether the unlock tracker restarts or wrongly keeps its progress. Pin reset pulses of one and of several cycles in every mode separate an abort with timed recovery from a direct return, and show where the recovery count restarts.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] UNLK_ADDR_1 = 12'h555;
    localparam logic [ADDR_W-1:0] UNLK_ADDR_2 = 12'hAAA;
    localparam logic [DATA_W-1:0] UNLK_DATA_1 = 8'hAA;
    localparam logic [DATA_W-1:0] UNLK_DATA_2 = 8'h55;
    localparam logic [DATA_W-1:0] CMD_RESET   = 8'hF0;

    localparam int ERR_BIT = 5;
    localparam int RDY_BIT = 7;

    typedef enum logic [2:0] {
        MODE_READ  = 3'd0,
        MODE_QUERY = 3'd1,
        MODE_PROG  = 3'd2,
        MODE_BULK  = 3'd3,
        MODE_SECT  = 3'd4,
        MODE_ERR   = 3'd5,
        MODE_RECOV = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_GOT1 = 2'd1,
        UL_GOT2 = 2'd2
    } ulk_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic is_array_op(mode_e m);
        return (m == MODE_PROG) || (m == MODE_BULK) || (m == MODE_SECT);
    endfunction

    function automatic mode_e op_to_mode(logic [1:0] kind);
        mode_e m;
        case (kind)
            2'd0:    m = MODE_QUERY;
            2'd1:    m = MODE_PROG;
            2'd2:    m = MODE_BULK;
            default: m = MODE_SECT;
        endcase
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] make_status(logic rdy, logic err);
        logic [DATA_W-1:0] s;
        s = '0;
        s[RDY_BIT] = rdy;
        s[ERR_BIT] = err;
        return s;
    endfunction

    function automatic logic is_first_step(bus_wr_t w);
        return (w.addr == UNLK_ADDR_1) && (w.data == UNLK_DATA_1);
    endfunction

    function automatic logic is_second_step(bus_wr_t w);
        return (w.addr == UNLK_ADDR_2) && (w.data == UNLK_DATA_2);
    endfunction

endpackage

// File: rtl/flash_unlock_det.sv
module flash_unlock_det
    import flash_rst_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  bus_wr_t wr,
    output logic    rst_cmd
);

    ulk_e stg_q, stg_d;
    logic cmd_raw;

    always_comb begin
        stg_d   = stg_q;
        cmd_raw = 1'b0;
        if (wr.en) begin
            case (stg_q)
                UL_IDLE: begin
                    if (is_first_step(wr))
                        stg_d = UL_GOT1;
                    else if (wr.data == CMD_RESET)
                        cmd_raw = 1'b1;
                end
                UL_GOT1: begin
                    if (is_second_step(wr))
                        stg_d = UL_GOT2;
                    else if (is_first_step(wr))
                        stg_d = UL_GOT1;
                    else
                        stg_d = UL_IDLE;
                end
                UL_GOT2: begin
                    if (wr.data == CMD_RESET) begin
                        cmd_raw = 1'b1;
                        stg_d   = UL_IDLE;
                    end else if (is_first_step(wr)) begin
                        stg_d = UL_GOT1;
                    end else begin
                        stg_d = UL_IDLE;
                    end
                end
                default: stg_d = UL_IDLE;
            endcase
        end
        if (clr)
            stg_d = UL_IDLE;
    end

    assign rst_cmd = cmd_raw && !clr;

    always_ff @(posedge clk) begin
        if (rst)
            stg_q <= UL_IDLE;
        else
            stg_q <= stg_d;
    end

    // R4: the prefix progress only moves on a bus write
    assert_hold_idle_bus_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr.en && !clr) |=> (stg_q == $past(stg_q)));

    // R3: a recognised command leaves no prefix behind
    assert_cmd_clears_R3: assert property (@(posedge clk) disable iff (rst)
        rst_cmd |=> (stg_q == UL_IDLE));

    // R10: the pin discards the prefix
    assert_pin_clears_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (stg_q == UL_IDLE));

endmodule

// File: rtl/flash_recov_timer.sv
module flash_recov_timer #(
    parameter int CYC = 6250
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);

    localparam int CNT_W = (CYC < 2) ? 1 : $clog2(CYC + 1);
    localparam logic [CNT_W-1:0] START = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= START;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R8: once expired the timer stays expired until reloaded
    assert_stays_done_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done);

endmodule

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
    import flash_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_rst,
    input  logic       rst_cmd,
    input  logic       op_start,
    input  logic [1:0] op_kind,
    input  logic       arr_busy,
    input  logic       arr_fail,
    input  logic       tmr_done,
    output mode_e      mode,
    output logic       err_flag,
    output logic       tmr_load,
    output logic       abort_erase,
    output logic       abort_all
);

    mode_e mode_q, mode_d;
    logic  err_q, err_d;
    logic  ab_erase_d, ab_all_d;
    logic  ab_erase_q, ab_all_q;

    always_comb begin
        mode_d     = mode_q;
        err_d      = err_q;
        tmr_load   = 1'b0;
        ab_erase_d = 1'b0;
        ab_all_d   = 1'b0;
        if (pin_rst) begin
            if (is_array_op(mode_q)) begin
                mode_d   = MODE_RECOV;
                tmr_load = 1'b1;
                ab_all_d = 1'b1;
            end else if (mode_q == MODE_RECOV) begin
                tmr_load = 1'b1;
            end else begin
                mode_d = MODE_READ;
            end
        end else begin
            case (mode_q)
                MODE_READ: begin
                    if (op_start)
                        mode_d = op_to_mode(op_kind);
                end
                MODE_QUERY: begin
                    if (rst_cmd)
                        mode_d = MODE_READ;
                end
                MODE_PROG, MODE_BULK, MODE_SECT: begin
                    if (mode_q == MODE_SECT && rst_cmd) begin
                        mode_d     = MODE_RECOV;
                        tmr_load   = 1'b1;
                        ab_erase_d = 1'b1;
                    end else if (!arr_busy) begin
                        if (arr_fail) begin
                            mode_d = MODE_ERR;
                            err_d  = 1'b1;
                        end else begin
                            mode_d = MODE_READ;
                        end
                    end
                end
                MODE_ERR: begin
                    if (rst_cmd) begin
                        mode_d   = MODE_RECOV;
                        tmr_load = 1'b1;
                    end
                end
                MODE_RECOV: begin
                    if (tmr_done)
                        mode_d = MODE_READ;
                end
                default: mode_d = MODE_READ;
            endcase
        end
        if (mode_d == MODE_READ)
            err_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_READ;
            err_q      <= 1'b0;
            ab_erase_q <= 1'b0;
            ab_all_q   <= 1'b0;
        end else begin
            mode_q     <= mode_d;
            err_q      <= err_d;
            ab_erase_q <= ab_erase_d;
            ab_all_q   <= ab_all_d;
        end
    end

    assign mode        = mode_q;
    assign err_flag    = err_q;
    assign abort_erase = ab_erase_q;
    assign abort_all   = ab_all_q;

    // R8: the erase abort strobe follows a sector erase and starts recovery
    assert_erase_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        abort_erase |-> (mode_q == MODE_RECOV && $past(mode_q) == MODE_SECT));

    // R8: erase abort lasts one cycle
    assert_erase_width_R8: assert property (@(posedge clk) disable iff (rst)
        abort_erase |=> !abort_erase);

    // R10: abort-all lasts one cycle
    assert_all_width_R10: assert property (@(posedge clk) disable iff (rst)
        abort_all |=> !abort_all);

    // R7: program and bulk erase keep running while the array is busy
    assert_prog_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PROG && arr_busy && !pin_rst) |=> (mode_q == MODE_PROG));
    assert_bulk_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_BULK && arr_busy && !pin_rst) |=> (mode_q == MODE_BULK));

    // R6: the error mode always shows the error flag
    assert_err_shown_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ERR) |-> err_q);

    // R9: normal read mode never carries the error flag
    assert_read_clean_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_READ) |-> !err_q);

    // R10: the pin always leads to read mode or recovery
    assert_pin_target_R10: assert property (@(posedge clk) disable iff (rst)
        pin_rst |=> (mode_q == MODE_READ || mode_q == MODE_RECOV));

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
    import flash_rst_pkg::*;
#(
    parameter int CLK_MHZ  = 250,
    parameter int RECOV_US = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_rst,
    input  logic        wr_en,
    input  logic [11:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        op_start,
    input  logic [1:0]  op_kind,
    input  logic        arr_busy,
    input  logic        arr_fail,
    output logic [2:0]  mode,
    output logic        ready,
    output logic        read_status,
    output logic [7:0]  status,
    output logic        abort_erase,
    output logic        abort_all
);

    localparam int RECOV_CYC = (CLK_MHZ * RECOV_US < 1) ? 1 : CLK_MHZ * RECOV_US;

    bus_wr_t bus;
    logic    rst_cmd;
    logic    tmr_load;
    logic    tmr_done;
    logic    err_flag;
    mode_e   mode_w;

    assign bus.en   = wr_en;
    assign bus.addr = wr_addr;
    assign bus.data = wr_data;

    flash_unlock_det u_unlock (
        .clk     (clk),
        .rst     (rst),
        .clr     (pin_rst),
        .wr      (bus),
        .rst_cmd (rst_cmd)
    );

    flash_recov_timer #(.CYC(RECOV_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .done (tmr_done)
    );

    flash_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pin_rst     (pin_rst),
        .rst_cmd     (rst_cmd),
        .op_start    (op_start),
        .op_kind     (op_kind),
        .arr_busy    (arr_busy),
        .arr_fail    (arr_fail),
        .tmr_done    (tmr_done),
        .mode        (mode_w),
        .err_flag    (err_flag),
        .tmr_load    (tmr_load),
        .abort_erase (abort_erase),
        .abort_all   (abort_all)
    );

    assign mode        = mode_w;
    assign ready       = !(is_array_op(mode_w) || mode_w == MODE_RECOV);
    assign read_status = (mode_w != MODE_READ);
    assign status      = make_status(ready, err_flag);

    // R10: the two abort strobes never fire together
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({abort_erase, abort_all}));

    // R8: recovery ends only into read mode
    assert_recov_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_w == MODE_RECOV && !pin_rst) |=> (mode_w == MODE_RECOV || mode_w == MODE_READ));

endmodule

// File: tb/test_flash_rst_seq.sv
module test_flash_rst_seq;

    localparam int MHZ = 2;
    localparam int US  = 3;
    localparam int N   = MHZ * US;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = '0;
    logic        arr_busy = 1'b0;
    logic        arr_fail = 1'b0;
    logic [2:0]  mode;
    logic        ready, read_status, abort_erase, abort_all;
    logic [7:0]  status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    flash_rst_seq #(.CLK_MHZ(MHZ), .RECOV_US(US)) i_flash_rst_seq (
        .clk(clk), .rst(rst), .pin_rst(pin_rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .op_start(op_start), .op_kind(op_kind), .arr_busy(arr_busy),
        .arr_fail(arr_fail), .mode(mode), .ready(ready), .read_status(read_status),
        .status(status), .abort_erase(abort_erase), .abort_all(abort_all)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_rst();
        @(negedge clk); rst = 1'b1; arr_busy = 1'b0; arr_fail = 1'b0; pin_rst = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reset_cmd(input bit prefixed);
        if (prefixed) begin
            wr(12'h555, 8'hAA);
            wr(12'hAAA, 8'h55);
        end
        wr(12'h3C1, 8'hF0);
    endtask

    task automatic start_op(input int kind);
        @(negedge clk); arr_busy = (kind != 0); op_start = 1'b1; op_kind = 2'(kind);
        @(negedge clk); op_start = 1'b0;
    endtask

    task automatic finish_op(input bit fail);
        @(negedge clk); arr_busy = 1'b0; arr_fail = fail;
        @(negedge clk); arr_fail = 1'b0;
    endtask

    task automatic pin_pulse(input int cycles);
        @(negedge clk); pin_rst = 1'b1;
        repeat (cycles) @(negedge clk);
        pin_rst = 1'b0;
    endtask

    task automatic measure(output int c);
        c = 0;
        while (!ready) begin
            c++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c;
        do_rst();
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 ready", ready, 1);
        chk("R1 read_status", read_status, 0);
        chk("R1 status", status, 8'h80);
        chk("R1 strobes", {abort_erase, abort_all}, 0);

        // R2 reset in read mode does nothing
        reset_cmd(0);
        chk("R2 read unchanged", mode, 0);
        chk("R2 no strobe", {abort_erase, abort_all}, 0);

        // R5 R7 R8 R2 R3 R11: every operation kind with both command forms
        for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 2; f++) begin
                do_rst();
                start_op(k);
                chk("R5 mode", mode, k + 1);
                chk("R5 ready", ready, (k == 0) ? 1 : 0);
                chk("R11 read_status", read_status, 1);
                chk("R11 status", status, (k == 0) ? 8'h80 : 8'h00);
                reset_cmd(f[0]);
                if (k == 0) begin
                    chk(f ? "R3 prefixed query exit" : "R2 single query exit", mode, 0);
                end else if (k < 3) begin
                    chk("R7 ignored", mode, k + 1);
                    chk("R7 no strobe", {abort_erase, abort_all}, 0);
                    finish_op(0);
                    chk("R6 clean end", mode, 0);
                end else begin
                    chk("R8 recov mode", mode, 6);
                    chk("R8 abort_erase", abort_erase, 1);
                    measure(c);
                    chk("R8 recovery length", c, N);
                    chk("R8 back to read", mode, 0);
                    chk("R8 strobe gone", abort_erase, 0);
                end
            end
        end

        // R5 op_start ignored outside read mode
        do_rst();
        start_op(1);
        @(negedge clk); op_start = 1'b1; op_kind = 2'd3;
        @(negedge clk); op_start = 1'b0;
        chk("R5 start ignored", mode, 2);

        // R6 R9 failures then reset from error
        for (int k = 1; k < 4; k++) begin
            do_rst();
            start_op(k);
            finish_op(1);
            chk("R6 error mode", mode, 5);
            chk("R6 status err", status, 8'hA0);
            reset_cmd(k[0]);
            chk("R9 recov", mode, 6);
            chk("R9 err kept", status, 8'h20);
            measure(c);
            chk("R9 recovery length", c, N);
            chk("R9 err cleared", status, 8'h80);
        end

        // R4 prefix corner cases from query mode
        do_rst(); start_op(0);
        wr(12'h555, 8'hAA); wr(12'hAAA, 8'hF0);
        chk("R4 F0 as second step", mode, 1);
        do_rst(); start_op(0);
        wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'hAA); wr(12'h100, 8'hF0);
        chk("R4 restart is mid prefix", mode, 1);
        do_rst(); start_op(0);
        wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55);
        wr(12'h100, 8'hF0);
        chk("R4 restarted prefix", mode, 0);
        do_rst(); start_op(0);
        wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'h90);
        chk("R4 other command", mode, 1);
        wr(12'h100, 8'hF0);
        chk("R4 prefix cleared", mode, 0);
        do_rst(); start_op(0);
        wr(12'h555, 8'hAA); wr(12'hAAB, 8'h55); wr(12'h100, 8'hF0);
        chk("R4 wrong address", mode, 0);
        do_rst(); start_op(0);
        wr(12'h555, 8'hAA); wr(12'hAAA, 8'h56); wr(12'h100, 8'hF0);
        chk("R4 wrong data", mode, 0);

        // R10 pin reset during array operations
        for (int k = 1; k < 4; k++) begin
            do_rst();
            start_op(k);
            pin_pulse(1);
            arr_busy = 1'b0;
            chk("R10 abort_all", abort_all, 1);
            chk("R10 recov", mode, 6);
            chk("R10 no erase strobe", abort_erase, 0);
            measure(c);
            chk("R10 recovery length", c, N);
            chk("R10 read", mode, 0);
        end
        do_rst();
        start_op(3);
        @(negedge clk); pin_rst = 1'b1;
        @(negedge clk); arr_busy = 1'b0;
        chk("R10 strobe first", abort_all, 1);
        @(negedge clk);
        chk("R10 strobe once", abort_all, 0);
        @(negedge clk); pin_rst = 1'b0;
        measure(c);
        chk("R10 held pin length", c, N);

        // R10 pin in query and error modes
        do_rst(); start_op(0);
        pin_pulse(1);
        chk("R10 query to read", mode, 0);
        chk("R10 query no strobe", abort_all, 0);
        do_rst(); start_op(2); finish_op(1);
        pin_pulse(1);
        chk("R10 err to read", mode, 0);
        chk("R10 err cleared", status, 8'h80);
        // R10 pin discards a partial prefix
        do_rst(); start_op(0);
        wr(12'h555, 8'hAA);
        pin_pulse(1);
        start_op(0);
        wr(12'hAAA, 8'hF0);
        chk("R10 prefix discarded", mode, 0);

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule